// File: doc/BRIEF.md
# Serial Command-Address Register Interface

This block is a synchronous serial slave that gives a host controller access to a 64-entry, 8-bit register file over four wires. The wires are an active-low select, a shift clock, serial data in and serial data out. The host frames each transfer in 8-bit groups, sent most significant bit first. The first group of a frame carries a 2-bit command in its upper bits and a 6-bit register address in its lower bits. Later groups carry write data.

Reads are pipelined. A read command fetches the addressed register into a holding register. The host receives that value during the first group of the next frame, while it shifts in the next command. Besides the read, the block supports a no-operation command, a two-byte standard write, and a burst write that stores every following group at the same address until the select is released.

The serial pins are brought into the core clock domain through synchronisers and edge detectors. The shift clock must therefore be slow compared with the core clock: its period must be at least 8 core cycles. The register-file side has an address, a one-cycle write strobe, write data, and read data that the register file returns combinationally.

Top module: `sercmd_regif`

## Requirements
- R1: Frames take effect only while `mode_sel` equals 2'b10. With any other value, a frame causes no write strobe, leaves the read holding register unchanged, and `sdo` stays 0.
- R2: Serial bits are sampled on the rising shift-clock edge, most significant bit first. In the first group of a frame, bits 7:6 are the command and bits 5:0 are the register address.
- R3: Command 2'b01 is a standard write. The group after the command group is written once to the address. Any further groups in that frame are ignored.
- R4: Command 2'b11 is a burst write. Every complete group after the command group is written to the same address, with one strobe per group, until `cs_n` rises.
- R5: Command 2'b00 is a read. When the eighth bit of the command group arrives, the addressed register is captured into the holding register. During the first group of every later active frame, `sdo` presents the holding register, most significant bit first, and changes after falling shift-clock edges.
- R6: Command 2'b10 is a no-operation. It produces no write and does not alter the holding register.
- R7: `sdo` is 0 after the first group of a frame and whenever the frame is inactive.
- R8: Raising `cs_n` discards any partly received group and returns the frame to command decoding. The next frame decodes correctly from its first bit.
- R9: The holding register keeps its value across frames that are not reads.
- R10: `reg_we` is a single-cycle pulse, and `reg_addr` and `reg_wdata` are valid in that cycle.
- R11: After reset, `sdo` and `reg_we` are 0 and the holding register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Interface strap; the block is active at 2'b10 |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| reg_addr | output | 6 | Register-file address |
| reg_we | output | 1 | Register-file write strobe |
| reg_wdata | output | 8 | Register-file write data |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
The bench targets the one-frame lag of read data. A design that streamed the current address would return the wrong byte in the frame after a read. It would also corrupt the returned value after a write or no-operation frame, because those frames must leave the holding register alone.

The bench sends extra groups after a standard write and long bursts. A design that kept writing after a standard write, or stopped after the first burst group, would show a mismatched strobe count and wrong register contents.

The bench aborts a frame partway through a group and then sends a fresh frame. A bit counter that survived the release of the select would misalign the next command.

Frames sent with the wrong mode strap must leave the strobe count, the memory and `sdo` untouched.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
   localparam int CMD_W = 2;

   typedef enum logic [CMD_W-1:0] {
      CMD_READ  = 2'b00,
      CMD_WRITE = 2'b01,
      CMD_NOP   = 2'b10,
      CMD_BURST = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      PH_HEAD = 2'b00,
      PH_DATA = 2'b01,
      PH_DONE = 2'b10
   } phase_e;
endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= RESET_VAL;
            else        chain <= din;
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], din};
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sercmd_frame.sv
module sercmd_frame import sercmd_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    active,
   input  logic                    bit_rise,
   input  logic                    bit_in,
   output logic [DATA_W-CMD_W-1:0] reg_addr,
   output logic                    reg_we,
   output logic [DATA_W-1:0]       reg_wdata,
   output logic                    rd_req
);
   localparam int ADDR_W = DATA_W - CMD_W;
   localparam int CNT_W  = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] full_byte;
   cmd_e              cmd_q, head_cmd;
   phase_e            phase;

   assign full_byte = {rx_sr[DATA_W-2:0], bit_in};
   assign head_cmd  = cmd_e'(full_byte[DATA_W-1 -: CMD_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         rx_sr     <= '0;
         cmd_q     <= CMD_NOP;
         phase     <= PH_HEAD;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_we    <= 1'b0;
         rd_req    <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         rd_req <= 1'b0;
         if (!active) begin
            bit_cnt <= '0;
            phase   <= PH_HEAD;
         end else if (bit_rise) begin
            rx_sr <= full_byte;
            if (bit_cnt != LAST_BIT) begin
               bit_cnt <= bit_cnt + 1'b1;
            end else begin
               bit_cnt <= '0;
               unique case (phase)
                  PH_HEAD: begin
                     cmd_q    <= head_cmd;
                     reg_addr <= full_byte[ADDR_W-1:0];
                     rd_req   <= (head_cmd == CMD_READ);
                     phase    <= (head_cmd == CMD_WRITE || head_cmd == CMD_BURST)
                                 ? PH_DATA : PH_DONE;
                  end
                  PH_DATA: begin
                     reg_we    <= 1'b1;
                     reg_wdata <= full_byte;
                     if (cmd_q != CMD_BURST) phase <= PH_DONE;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // R10: one strobe per received group, never two in a row
   p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R3: strobes only come out of the data phase
   p_we_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(phase == PH_DATA));
   // R3: after a completed frame nothing more is written
   p_done_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> !reg_we);
   // R5: a fetch is only requested by a read command
   p_rdreq_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (cmd_q == CMD_READ));
   // R6: no-op never leads to a write
   p_nop_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_NOP && phase != PH_HEAD) |=> !reg_we);
endmodule

// File: rtl/sercmd_txpipe.sv
module sercmd_txpipe #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              start,
   input  logic              bit_fall,
   input  logic              rd_req,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sdo
);
   logic [DATA_W-1:0] rd_pipe;
   logic [DATA_W-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_pipe <= '0;
      else if (rd_req) rd_pipe <= reg_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_sr <= '0;
      else if (!active)  tx_sr <= '0;
      else if (start)    tx_sr <= rd_pipe;
      else if (bit_fall) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
   end

   assign sdo = tx_sr[DATA_W-1];

   // R5: the fetch lands in the holding register one cycle later
   p_pipe_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> (rd_pipe == $past(reg_rdata)));
   // R9: without a fetch the holding register is kept
   p_pipe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(rd_pipe));
   // R7: an inactive frame drives a low output
   p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !sdo);
endmodule

// File: rtl/sercmd_regif.sv
module sercmd_regif import sercmd_pkg::*; #(
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [1:0] ACTIVE_MODE = 2'b10
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              mode_sel,
   input  logic                    cs_n,
   input  logic                    sclk,
   input  logic                    sdi,
   output logic                    sdo,
   output logic [DATA_W-CMD_W-1:0] reg_addr,
   output logic                    reg_we,
   output logic [DATA_W-1:0]       reg_wdata,
   input  logic [DATA_W-1:0]       reg_rdata
);
   initial begin
      assert (DATA_W > CMD_W + 1) else $error("DATA_W too small for command and address");
      assert (SYNC_STAGES >= 2)   else $error("SYNC_STAGES must be at least 2");
   end

   logic cs_n_s, sclk_s, sdi_s;
   logic sclk_d, act_d;
   logic frame_act, bit_rise, bit_fall, start, rd_req;

   sercmd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .dout(cs_n_s));
   sercmd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sk (
      .clk(clk), .rst_n(rst_n), .din(sclk), .dout(sclk_s));
   sercmd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_di (
      .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         act_d  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         act_d  <= frame_act;
      end
   end

   assign frame_act = (mode_sel == ACTIVE_MODE) && !cs_n_s;
   assign bit_rise  = frame_act &&  sclk_s && !sclk_d;
   assign bit_fall  = frame_act && !sclk_s &&  sclk_d;
   assign start     = frame_act && !act_d;

   sercmd_frame #(.DATA_W(DATA_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .active(frame_act), .bit_rise(bit_rise),
      .bit_in(sdi_s), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .rd_req(rd_req));

   sercmd_txpipe #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .active(frame_act), .start(start),
      .bit_fall(bit_fall), .rd_req(rd_req), .reg_rdata(reg_rdata), .sdo(sdo));

   // R1: a wrong strap blocks any write in the following cycle
   p_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel != ACTIVE_MODE) |=> !reg_we);
   // R8: a released select starts the next frame in command decoding
   p_release_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_act && act_d) |=> !reg_we);
endmodule

// File: tb/sercmd_regif_test.sv
module sercmd_regif_test;
   localparam int CLK_T = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b10;
   logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic       sdo, reg_we;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0] mem [64];
   logic [7:0] exp_mem [64];
   logic [7:0] exp_pipe;
   logic [7:0] fb [8];
   int we_cnt, exp_we, n_chk, n_err;
   bit done;

   always #(CLK_T/2) clk = ~clk;

   sercmd_regif uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .sclk(sclk),
      .sdi(sdi), .sdo(sdo), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 37 + 11) & 8'hFF);
   endfunction

   assign reg_rdata = mem[reg_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
         we_cnt <= 0;
      end else if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic partial_frame(input int nbits);
      @(negedge clk) cs_n = 1'b0;
      wclk(8);
      for (int i = 0; i < nbits; i++) begin
         sdi = 1'b1; wclk(8); sclk = 1'b1; wclk(8); sclk = 1'b0;
      end
      wclk(4); cs_n = 1'b1; wclk(12);
   endtask

   task automatic run_frame(input int n, input logic [1:0] md, input string req);
      logic [7:0] got = '0;
      logic [7:0] exp_rd;
      logic [1:0] cmd;
      logic [5:0] a;
      bit tail = 1'b0;
      bit act;
      mode_sel = md;
      @(negedge clk) cs_n = 1'b0;
      wclk(8);
      for (int b = 0; b < n; b++) begin
         for (int i = 7; i >= 0; i--) begin
            sdi = fb[b][i];
            wclk(8);
            if (b == 0) got[i] = sdo;
            else if (sdo) tail = 1'b1;
            sclk = 1'b1; wclk(8); sclk = 1'b0;
         end
         wclk(6);
      end
      wclk(10); cs_n = 1'b1; wclk(12);
      mode_sel = 2'b10;
      act    = (md == 2'b10);
      exp_rd = act ? exp_pipe : 8'h00;
      cmd    = fb[0][7:6];
      a      = fb[0][5:0];
      check(got == exp_rd, {req, " R5 returned byte"}, got, exp_rd);
      check(!tail, {req, " R7 tail zero"}, tail, 0);
      if (act) begin
         case (cmd)
            2'b00: exp_pipe = exp_mem[a];
            2'b01: if (n > 1) begin exp_mem[a] = fb[1]; exp_we++; end
            2'b11: for (int b = 1; b < n; b++) begin exp_mem[a] = fb[b]; exp_we++; end
            default: ;
         endcase
      end
      check(we_cnt == exp_we, {req, " R10 strobe count"}, we_cnt, exp_we);
      check(mem[a] == exp_mem[a], {req, " R2 register value"}, mem[a], exp_mem[a]);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
      exp_pipe = 8'h00; exp_we = 0; n_chk = 0; n_err = 0;
      wclk(4); rst_n = 1'b1; wclk(4);
      check(sdo == 1'b0, "R11 reset sdo", sdo, 0);
      check(reg_we == 1'b0, "R11 reset strobe", reg_we, 0);
      // R11 then R5: first read returns reset pipe 0
      fb[0] = {2'b00, 6'd5};                        run_frame(1, 2'b10, "R11");
      fb[0] = {2'b10, 6'd9};                        run_frame(1, 2'b10, "R6");
      // R3: extra groups after a standard write ignored
      fb[0] = {2'b01, 6'd9}; fb[1] = 8'hA5; fb[2] = 8'h3C;
      run_frame(3, 2'b10, "R3");
      fb[0] = {2'b00, 6'd9};                        run_frame(1, 2'b10, "R9");
      fb[0] = {2'b00, 6'd63};                       run_frame(1, 2'b10, "R5");
      // R4: burst of five to address 0
      fb[0] = {2'b11, 6'd0};
      for (int b = 1; b < 6; b++) fb[b] = 8'(8'h10 * b + 1);
      run_frame(6, 2'b10, "R4");
      // R1: wrong strap, write must be ignored
      fb[0] = {2'b01, 6'd20}; fb[1] = 8'hEE;       run_frame(2, 2'b00, "R1");
      fb[0] = {2'b11, 6'd20}; fb[1] = 8'hEF;       run_frame(2, 2'b11, "R1");
      fb[0] = {2'b00, 6'd20};                       run_frame(1, 2'b10, "R1");
      // R8: aborted group, then a clean write
      partial_frame(5);
      fb[0] = {2'b01, 6'd33}; fb[1] = 8'h5A;       run_frame(2, 2'b10, "R8");
      partial_frame(11);
      fb[0] = {2'b00, 6'd33};                       run_frame(1, 2'b10, "R8");
      fb[0] = {2'b10, 6'd0};                        run_frame(1, 2'b10, "R5");
      // random mix, fixed seed
      void'($urandom(32'h5EED));
      for (int k = 0; k < 60; k++) begin
         int n;
         n = 1 + int'($urandom_range(0, 4));
         for (int b = 0; b < n; b++) fb[b] = 8'($urandom);
         run_frame(n, ($urandom_range(0, 9) == 0) ? 2'b01 : 2'b10, "R2");
      end
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule